// File: doc/BRIEF.md
# Shared-Memory Slot Arbiter with Scan-Driven Refresh

This block lets a processor and a display scanner share one dynamic memory without a refresh controller. Time is cut into fixed slots of four memory clocks. Slots alternate strictly between the processor and the scanner, so each side gets exactly half of the memory bandwidth. With a 2 MHz slot clock and four-clock slots, for example, each side receives one access per microsecond.

The scanner walks a character counter and a line counter. It forms its word address as `{line, char}`. The memory row is taken from the low bits of that word address, and the column from the bits above them. Consecutive scanner fetches therefore step across rows rather than along one row. Because reading any cell in a row restores the whole row, the scan reads alone refresh every row long before its deadline. When the character field is at least as wide as the row field, any window of `2 * 2^ROW_W` slots activates every row at least once.

The processor side is a valid/ready stream with no back-pressure wait beyond slot alignment. `cpu_ready` is high in the first clock of every processor slot. A request is taken when `cpu_req` and `cpu_ready` are both high. The processor holds `cpu_req`, `cpu_we` and `cpu_addr` until that clock, and may change them freely afterwards. The two valid strobes cannot be back-pressured, so their sinks must take the data in the clock they are high.

Top module: `dram_slot_arbiter`

## Requirements
- R1: Slots last four clocks, numbered phase 0 to 3. After reset the first slot belongs to the processor (`slot_owner`=0). Ownership then alternates every slot, with the scanner (`slot_owner`=1) taking every second slot.
- R2: While `rst` is high, `ras_n`, `cas_n` and `we_n` are high, and `cpu_ready`, `cpu_rvalid` and `vid_valid` are low. After reset is released, the scan restarts at line 0, char 0, and phase 0 of a processor slot.
- R3: `cpu_ready` is high only in phase 0 of a processor slot. A request is accepted only when `cpu_req` and `cpu_ready` are both high. `cpu_req` in a scanner slot has no effect. Address and write flag are captured at acceptance, and later changes to them do not affect the slot.
- R4: In every active slot, `mem_addr` carries the row (word address bits `[ROW_W-1:0]`) in phases 0 and 1, and the column (bits `[ROW_W+COL_W-1:ROW_W]`) in phases 2 and 3. `ras_n` is low in phases 1 to 3, and `cas_n` is low in phase 3 only. The row strobe therefore always precedes the column strobe, and the row address is stable when `ras_n` falls.
- R5: An accepted read raises `cpu_rvalid` in phase 3 of the same slot. An accepted write drives `we_n` low in phases 2 and 3 and raises no `cpu_rvalid`.
- R6: A processor slot with no accepted request leaves `ras_n`, `cas_n` and `we_n` high and `cpu_rvalid` low for the whole slot.
- R7: Every scanner slot is active. Its word address is `{line, char}`, it never writes, and it raises `vid_valid` in phase 3.
- R8: After each scanner slot, char advances by one. When char wraps from `2^CHAR_W-1` to 0, line advances. When line passes `LINES-1`, it returns to 0 and a new frame starts.
- R9: When `CHAR_W >= ROW_W`, each of the `2^ROW_W` rows is activated within every run of `2*2^ROW_W` slots counted from reset, with no dedicated refresh cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | Processor request is a write |
| cpu_addr | input | ROW_W+COL_W | Processor word address |
| cpu_ready | output | 1 | Request accepted this clock when `cpu_req` is high |
| cpu_rvalid | output | 1 | Processor read data valid on the memory bus |
| vid_valid | output | 1 | Scanner read data valid on the memory bus |
| slot_owner | output | 1 | 0 = processor slot, 1 = scanner slot |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The bench builds the block with `ROW_W`=4, `COL_W`=4, `CHAR_W`=5 and `LINES`=6. With these values a frame is only 192 scanner fetches, so the char wrap, the line wrap and the frame wrap all occur several times in a short run. The 16-row refresh window of 32 slots also closes many times, both with processor traffic mixed in and with idle processor slots. A reset issued mid-slot checks that the scan restarts from its first address.

// File: rtl/dram_slot_pkg.sv
package dram_slot_pkg;
  typedef enum logic [1:0] {
    PH_ROW = 2'd0,
    PH_RAS = 2'd1,
    PH_COL = 2'd2,
    PH_CAS = 2'd3
  } slot_phase_e;

  typedef enum logic {
    OWN_CPU = 1'b0,
    OWN_VID = 1'b1
  } owner_e;
endpackage

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import dram_slot_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output slot_phase_e phase,
  output owner_e      owner
);
  logic [1:0] ph_q;
  logic       own_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= 2'd0;
      own_q <= 1'b0;
    end else begin
      ph_q <= ph_q + 2'd1;
      if (ph_q == 2'd3) own_q <= ~own_q;
    end
  end

  assign phase = slot_phase_e'(ph_q);
  assign owner = owner_e'(own_q);
endmodule

// File: rtl/scan_counter.sv
module scan_counter #(
  parameter int CHAR_W = 7,
  parameter int LINE_W = 7,
  parameter int LINES  = 100
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     advance,
  output logic [LINE_W+CHAR_W-1:0] scan_addr
);
  localparam logic [CHAR_W-1:0] CHAR_LAST = {CHAR_W{1'b1}};
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

  logic [CHAR_W-1:0] chr_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chr_q  <= '0;
      line_q <= '0;
    end else if (advance) begin
      chr_q <= chr_q + 1'b1;
      if (chr_q == CHAR_LAST)
        line_q <= (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
    end
  end

  assign scan_addr = {line_q, chr_q};
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import dram_slot_pkg::*;
#(
  parameter int ROW_W = 7,
  parameter int COL_W = 7,
  parameter int MUX_W = 7
) (
  input  slot_phase_e              phase,
  input  logic                     act,
  input  logic                     wr,
  input  logic [ROW_W+COL_W-1:0]   word,
  output logic [MUX_W-1:0]         mem_addr,
  output logic                     ras_n,
  output logic                     cas_n,
  output logic                     we_n
);
  logic [MUX_W-1:0] row_part;
  logic [MUX_W-1:0] col_part;

  assign row_part = MUX_W'(word[ROW_W-1:0]);
  assign col_part = MUX_W'(word[ROW_W+COL_W-1:ROW_W]);

  always_comb begin
    mem_addr = (phase == PH_ROW || phase == PH_RAS) ? row_part : col_part;
    ras_n    = !(act && phase != PH_ROW);
    cas_n    = !(act && phase == PH_CAS);
    we_n     = !(act && wr && (phase == PH_COL || phase == PH_CAS));
  end
endmodule

// File: rtl/dram_slot_arbiter.sv
module dram_slot_arbiter
  import dram_slot_pkg::*;
#(
  parameter int ROW_W  = 7,
  parameter int COL_W  = 7,
  parameter int CHAR_W = 7,
  parameter int LINES  = 100
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    cpu_req,
  input  logic                                    cpu_we,
  input  logic [ROW_W+COL_W-1:0]                  cpu_addr,
  output logic                                    cpu_ready,
  output logic                                    cpu_rvalid,
  output logic                                    vid_valid,
  output logic                                    slot_owner,
  output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0]    mem_addr,
  output logic                                    ras_n,
  output logic                                    cas_n,
  output logic                                    we_n
);
  localparam int AW     = ROW_W + COL_W;
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int LINE_W = AW - CHAR_W;

  slot_phase_e     phase;
  owner_e          owner;
  logic [AW-1:0]   scan_addr;
  logic [AW-1:0]   lat_addr;
  logic            lat_we;
  logic            act_q;
  logic            accept;
  logic            act;
  logic [AW-1:0]   slot_addr;
  logic            slot_we;

  slot_sequencer u_seq (
    .clk   (clk),
    .rst   (rst),
    .phase (phase),
    .owner (owner)
  );

  scan_counter #(
    .CHAR_W (CHAR_W),
    .LINE_W (LINE_W),
    .LINES  (LINES)
  ) u_scan (
    .clk       (clk),
    .rst       (rst),
    .advance   (owner == OWN_VID && phase == PH_CAS),
    .scan_addr (scan_addr)
  );

  assign cpu_ready = !rst && owner == OWN_CPU && phase == PH_ROW;
  assign accept    = cpu_ready && cpu_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      lat_addr <= '0;
      lat_we   <= 1'b0;
    end else if (phase == PH_ROW) begin
      act_q    <= (owner == OWN_VID) || accept;
      lat_addr <= cpu_addr;
      lat_we   <= cpu_we;
    end
  end

  always_comb begin
    if (phase == PH_ROW) act = !rst && ((owner == OWN_VID) || accept);
    else                 act = act_q;
    if (owner == OWN_VID)       slot_addr = scan_addr;
    else if (phase == PH_ROW)   slot_addr = cpu_addr;
    else                        slot_addr = lat_addr;
    if (owner == OWN_VID)       slot_we = 1'b0;
    else if (phase == PH_ROW)   slot_we = cpu_we;
    else                        slot_we = lat_we;
  end

  strobe_gen #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .MUX_W (MUX_W)
  ) u_strb (
    .phase    (phase),
    .act      (act),
    .wr       (slot_we),
    .word     (slot_addr),
    .mem_addr (mem_addr),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n)
  );

  assign cpu_rvalid = owner == OWN_CPU && phase == PH_CAS && act_q && !lat_we;
  assign vid_valid  = owner == OWN_VID && phase == PH_CAS;
  assign slot_owner = owner;
endmodule

// File: rtl/dram_slot_arbiter_chk.sv
module dram_slot_arbiter_chk #(
  parameter int ROW_W = 7,
  parameter int MUX_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       phase,
  input logic             slot_owner,
  input logic             cpu_req,
  input logic             cpu_ready,
  input logic             cpu_rvalid,
  input logic             vid_valid,
  input logic [MUX_W-1:0] mem_addr,
  input logic             ras_n,
  input logic             cas_n
);
  localparam int ROWS   = 1 << ROW_W;
  localparam int BUDGET = 2 * ROWS;
  localparam int AGE_W  = $clog2(BUDGET + 2) + 1;

  logic             ras_prev;
  logic [AGE_W-1:0] age [ROWS];
  logic             over_budget;

  always_ff @(posedge clk) begin
    if (rst) ras_prev <= 1'b1;
    else     ras_prev <= ras_n;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst)
        age[r] <= '0;
      else if (!ras_n && ras_prev && mem_addr[ROW_W-1:0] == ROW_W'(r))
        age[r] <= '0;
      else if (phase == 2'd0 && age[r] <= AGE_W'(BUDGET))
        age[r] <= age[r] + 1'b1;
    end
  end

  always_comb begin
    over_budget = 1'b0;
    for (int r = 0; r < ROWS; r++)
      if (age[r] > AGE_W'(BUDGET)) over_budget = 1'b1;
  end

  assert_owner_toggle_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd3) |=> (slot_owner != $past(slot_owner)));

  assert_cas_after_ras_R4: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> (!ras_n && $past(!ras_n)));

  assert_row_held_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $stable(mem_addr));

  assert_ready_slot_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> (!slot_owner && ras_n && cas_n));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready && !cpu_req) |=> ras_n);

  assert_rvalid_in_cas_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |-> (!cas_n && !slot_owner));

  assert_vvalid_in_cas_R7: assert property (@(posedge clk) disable iff (rst)
    vid_valid |-> (!cas_n && slot_owner));

  assert_row_age_R9: assert property (@(posedge clk) disable iff (rst)
    !over_budget);
endmodule

bind dram_slot_arbiter dram_slot_arbiter_chk #(
  .ROW_W (ROW_W),
  .MUX_W (MUX_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .phase      (phase),
  .slot_owner (slot_owner),
  .cpu_req    (cpu_req),
  .cpu_ready  (cpu_ready),
  .cpu_rvalid (cpu_rvalid),
  .vid_valid  (vid_valid),
  .mem_addr   (mem_addr),
  .ras_n      (ras_n),
  .cas_n      (cas_n)
);

// File: tb/sim_dram_slot_arbiter.sv
module sim_dram_slot_arbiter;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 4;
  localparam int CHAR_W = 5;
  localparam int LINES  = 6;
  localparam int AW     = ROW_W + COL_W;
  localparam int CHARS  = 1 << CHAR_W;
  localparam int ROWS   = 1 << ROW_W;

  // {req, we, addr}
  localparam logic [AW+1:0] VEC [16] = '{
    10'h2A5, 10'h33C, 10'h000, 10'h2F0, 10'h30F, 10'h1FF, 10'h281, 10'h25A,
    10'h3C3, 10'h07E, 10'h2FF, 10'h300, 10'h212, 10'h1AA, 10'h3E7, 10'h266
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_ready, cpu_rvalid, vid_valid, slot_owner;
  logic [3:0]    mem_addr;
  logic          ras_n, cas_n, we_n;

  int checks = 0;
  int fails  = 0;
  int vchar  = 0;
  int vline  = 0;
  int slot   = 0;
  logic [ROWS-1:0] seen = '0;

  always #10 clk = ~clk;

  dram_slot_arbiter #(
    .ROW_W (ROW_W), .COL_W (COL_W), .CHAR_W (CHAR_W), .LINES (LINES)
  ) u0 (
    .clk (clk), .rst (rst), .cpu_req (cpu_req), .cpu_we (cpu_we),
    .cpu_addr (cpu_addr), .cpu_ready (cpu_ready), .cpu_rvalid (cpu_rvalid),
    .vid_valid (vid_valid), .slot_owner (slot_owner), .mem_addr (mem_addr),
    .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n)
  );

  wire [10:0] obs = {mem_addr, ras_n, cas_n, we_n, slot_owner, cpu_ready, cpu_rvalid, vid_valid};

  task automatic chk(input string tag, input logic [10:0] exp, input logic addr_care);
    logic [10:0] m;
    m = addr_care ? 11'h7FF : 11'h07F;
    checks++;
    if ((obs & m) !== (exp & m)) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, obs & m, exp & m);
    end
  endtask

  task automatic end_slot();
    @(negedge clk);
    slot++;
    if (slot % (2 * ROWS) == 0) begin
      checks++;
      if (seen !== {ROWS{1'b1}}) begin
        fails++;
        $display("FAIL R9 row window: got %h expected %h", seen, {ROWS{1'b1}});
      end
      seen = '0;
    end
  endtask

  task automatic cpu_slot(input logic req, input logic we, input logic [AW-1:0] a);
    logic [3:0] r, c;
    r = a[3:0];
    c = a[7:4];
    cpu_req = req; cpu_we = we; cpu_addr = a;
    #1;
    chk("R1 R3 R4 cpu phase0", {r, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, req);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = ~we; cpu_addr = ~a;   // R3 later changes ignored
    #1;
    if (req) begin
      seen[mem_addr] = 1'b1;
      chk("R4 cpu phase1", {r, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, 1'b1);
    end else
      chk("R6 idle phase1", {r, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, 1'b0);
    @(negedge clk); #1;
    if (req) chk("R4 R5 cpu phase2", {c, 1'b0, 1'b1, ~we, 1'b0, 1'b0, 1'b0, 1'b0}, 1'b1);
    else     chk("R6 idle phase2", {c, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, 1'b0);
    @(negedge clk); #1;
    if (req) chk("R4 R5 cpu phase3", {c, 1'b0, 1'b0, ~we, 1'b0, 1'b0, ~we, 1'b0}, 1'b1);
    else     chk("R6 idle phase3", {c, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, 1'b0);
    end_slot();
  endtask

  task automatic vid_slot();
    logic [AW-1:0] sa;
    logic [3:0] r, c;
    sa = {3'(vline), 5'(vchar)};
    r = sa[3:0];
    c = sa[7:4];
    cpu_req = 1'b1; cpu_we = 1'b1;   // R3 no effect in scanner slot
    #1;
    chk("R1 R3 R7 vid phase0", {r, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, 1'b1);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    #1;
    seen[mem_addr] = 1'b1;
    chk("R4 R7 R8 vid phase1", {r, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, 1'b1);
    @(negedge clk); #1;
    chk("R4 R7 R8 vid phase2", {c, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, 1'b1);
    @(negedge clk); #1;
    chk("R7 vid phase3", {c, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, 1'b1);
    vchar++;
    if (vchar == CHARS) begin
      vchar = 0;
      vline++;
      if (vline == LINES) vline = 0;
    end
    end_slot();
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cpu_req = 1'b1;
    #1;
    chk("R2 reset state", {4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) begin
      cpu_slot(VEC[i][9], VEC[i][8], VEC[i][7:0]);
      vid_slot();
    end
    for (int i = 0; i < 200; i++) begin
      cpu_slot(1'b0, 1'b1, 8'h5A);
      vid_slot();
    end
    // mid-slot reset: two clocks into a processor slot
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    cpu_req = 1'b1;
    @(negedge clk); #1;
    chk("R2 mid-slot reset", {4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    vchar = 0; vline = 0; slot = 0; seen = '0;
    for (int i = 0; i < 20; i++) begin
      cpu_slot(i[0], 1'b0, 8'(i * 37));
      vid_slot();
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule